// File: doc/BRIEF.md
# Queue-Pair DMA Channel Controller

This block holds the control and status logic of one memory-to-memory copy channel. Software keeps a ring of submission entries and a ring of completion entries in host memory. It programs the ring bases and sizes through a 32-bit register port, then rings a doorbell by writing a new submission tail. The controller keeps its own submission head and completion tail. For each posted entry it offers the entry index to a separate fetch engine over a valid/ready handshake and waits for that engine to return a done result, with an error flag and the entry's local-interrupt request. On success it advances both internal pointers and may raise its interrupt line. The memory transactions and the copy datapath live in the fetch engine, outside this block.

To stop a channel, software sets pause and clears enable, then polls the state field until it leaves the busy value. It then issues a self-clearing channel reset, clears its ring pointers and enables the channel again. The state field is therefore part of the software contract. An error freezes the channel in a fault state until that reset.

The register offsets below are decoded within the channel's own block. Channel selection by address is left to the surrounding fabric.

Top module: `qpdma_chan_ctrl`

## Requirements
- R1: Register offsets: submission base low/high at 0x00/0x04, submission depth at 0x08, submission tail at 0x0C, completion base low/high at 0x10/0x14, completion depth at 0x18, completion head at 0x1C, control word at 0x20 (enable bit 0, pause bit 4), reset word at 0x24 (bit 0), state at 0x30 (bits 3:0), interrupt status at 0x40 and interrupt mask at 0x44 (13 bits each). After power-on reset both depth registers read DEPTH-1 (1023), the mask reads 0x1FFF, and status, control and state read 0. Base registers read back what was written.
- R2: When enabled, not paused and the internal submission head differs from the tail register, the block raises fetch_valid with fetch_idx equal to the head. fetch_valid and fetch_idx hold until fetch_ready. Entries are offered strictly in ring order, and none is offered while head equals tail.
- R3: Depth registers hold the entry count minus one. Each pointer steps from the value of its depth register back to 0.
- R4: Setting pause lets the entry in flight finish. The state then reads PAUSE (3) with fetch_valid low. Clearing pause resumes at the saved head.
- R5: If advancing the internal completion tail would make it equal to the completion head register, no entry is offered and the state reads WAIT (6). Writing a new completion head releases it.
- R6: A successful completion sets status bit 0 only when the entry requested a local interrupt.
- R7: A completion with the error flag sets status bit 1 and leaves both pointers unchanged. The state then reads ABORT (5) with no further entries offered until a channel reset.
- R8: Writing 1 to bit 0 of the reset word clears the submission head and the completion tail and drops any pending offer. The state reads BUFFCLR (7), and reset-word bit 0 reads 1, for exactly RESET_CYC cycles. After that the state reads IDLE (0).
- R9: irq is high when any status bit is set whose mask bit is 0. Writing ones to the status offset clears those bits.
- R10: While an entry is outstanding the state reads RUN (1). The cycle after a successful completion it reads CPL (2).
- R11: With enable clear, a doorbell write starts nothing: fetch_valid stays low and the state reads IDLE. Setting enable starts the posted entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the channel block |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fetch_valid | output | 1 | Entry index offered to the fetch engine |
| fetch_ready | input | 1 | Fetch engine accepts the offered index |
| fetch_idx | output | PTR_W | Submission ring index being offered |
| done_valid | input | 1 | Fetch engine reports the outstanding entry finished |
| done_err | input | 1 | The finished entry failed |
| done_irq_req | input | 1 | The finished entry asked for a local interrupt |
| irq | output | 1 | Channel interrupt |

## Verification
Directed sequences drive a four-entry ring through wrap-around, through a full completion ring, and through pause, disable, error and channel reset, each with a slow fetch engine so the intermediate states can be read back. The wrap test tells a correct modulo step apart from a binary roll-over. The full-ring test tells a WAIT stall apart from an overrun. The pause test tells finishing the in-flight entry apart from dropping or refetching it. A randomized phase on an eight-entry ring posts batches of random size, with random ready gaps, completion latencies and interrupt requests. It compares the offered index sequence and the completion status bit with a software ring model, which exposes ordering, skip and duplicate faults.

// File: rtl/qpdma_pkg.sv
package qpdma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_BUSY   = 4'd1,
    ST_DONE   = 4'd2,
    ST_PAUSED = 4'd3,
    ST_HALTED = 4'd4,
    ST_FAULT  = 4'd5,
    ST_CQFULL = 4'd6,
    ST_CLEAR  = 4'd7
  } chan_state_e;

  localparam logic [7:0] OFS_SQ_DEPTH = 8'h08;
  localparam logic [7:0] OFS_SQ_TAIL  = 8'h0C;
  localparam logic [7:0] OFS_CQ_DEPTH = 8'h18;
  localparam logic [7:0] OFS_CQ_HEAD  = 8'h1C;
  localparam logic [7:0] OFS_CTRL     = 8'h20;
  localparam logic [7:0] OFS_RESET    = 8'h24;
  localparam logic [7:0] OFS_STATE    = 8'h30;
  localparam logic [7:0] OFS_INT_STS  = 8'h40;
  localparam logic [7:0] OFS_INT_MSK  = 8'h44;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_PAUSE_BIT = 4;
  localparam int INT_W          = 13;
  localparam int INT_CPL_BIT    = 0;
  localparam int INT_ERR_BIT    = 1;

endpackage

// File: rtl/qpdma_regs.sv
module qpdma_regs
  import qpdma_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PTR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  chan_state_e       state,
  input  logic [INT_W-1:0]  int_sts,
  output logic [PTR_W-1:0]  sq_depth,
  output logic [PTR_W-1:0]  cq_depth,
  output logic [PTR_W-1:0]  sq_tail,
  output logic [PTR_W-1:0]  cq_head,
  output logic              enable,
  output logic              pause,
  output logic              rst_req,
  output logic              sts_clr_we,
  output logic [INT_W-1:0]  int_mask
);

  localparam logic [PTR_W-1:0] DEPTH_M1 = PTR_W'(DEPTH - 1);
  localparam int NBASE = 4;

  logic [31:0] base_q [NBASE];
  logic we_sqd, we_sqt, we_cqd, we_cqh, we_ctl, we_msk;

  always_comb begin
    we_sqd     = reg_wr && (reg_addr == OFS_SQ_DEPTH);
    we_sqt     = reg_wr && (reg_addr == OFS_SQ_TAIL);
    we_cqd     = reg_wr && (reg_addr == OFS_CQ_DEPTH);
    we_cqh     = reg_wr && (reg_addr == OFS_CQ_HEAD);
    we_ctl     = reg_wr && (reg_addr == OFS_CTRL);
    we_msk     = reg_wr && (reg_addr == OFS_INT_MSK);
    sts_clr_we = reg_wr && (reg_addr == OFS_INT_STS);
    rst_req    = reg_wr && (reg_addr == OFS_RESET) && reg_wdata[0];
  end

  // Ring base words: submission pair at 0x00/0x04, completion pair at 0x10/0x14
  for (genvar g = 0; g < NBASE; g++) begin : g_base
    localparam logic [7:0] OFS = 8'((g / 2) * 16 + (g % 2) * 4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              base_q[g] <= '0;
      else if (reg_wr && (reg_addr == OFS))    base_q[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_depth <= DEPTH_M1;
      cq_depth <= DEPTH_M1;
      sq_tail  <= '0;
      cq_head  <= '0;
      enable   <= 1'b0;
      pause    <= 1'b0;
      int_mask <= '1;
    end else begin
      if (we_sqd) sq_depth <= reg_wdata[PTR_W-1:0];
      if (we_cqd) cq_depth <= reg_wdata[PTR_W-1:0];
      if (we_sqt) sq_tail  <= reg_wdata[PTR_W-1:0];
      if (we_cqh) cq_head  <= reg_wdata[PTR_W-1:0];
      if (we_ctl) begin
        enable <= reg_wdata[CTRL_EN_BIT];
        pause  <= reg_wdata[CTRL_PAUSE_BIT];
      end
      if (we_msk) int_mask <= reg_wdata[INT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00:        reg_rdata = base_q[0];
      8'h04:        reg_rdata = base_q[1];
      8'h10:        reg_rdata = base_q[2];
      8'h14:        reg_rdata = base_q[3];
      OFS_SQ_DEPTH: reg_rdata = 32'(sq_depth);
      OFS_SQ_TAIL:  reg_rdata = 32'(sq_tail);
      OFS_CQ_DEPTH: reg_rdata = 32'(cq_depth);
      OFS_CQ_HEAD:  reg_rdata = 32'(cq_head);
      OFS_CTRL: begin
        reg_rdata[CTRL_EN_BIT]    = enable;
        reg_rdata[CTRL_PAUSE_BIT] = pause;
      end
      OFS_RESET:    reg_rdata[0] = (state == ST_CLEAR);
      OFS_STATE:    reg_rdata[3:0] = state;
      OFS_INT_STS:  reg_rdata = 32'(int_sts);
      OFS_INT_MSK:  reg_rdata = 32'(int_mask);
      default:      reg_rdata = '0;
    endcase
  end

  // R1: a mask write is visible on the next cycle
  assert_mask_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_msk |=> (int_mask == $past(reg_wdata[INT_W-1:0])));

endmodule

// File: rtl/qpdma_seq.sv
module qpdma_seq
  import qpdma_pkg::*;
#(
  parameter int PTR_W     = 10,
  parameter int RESET_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pause,
  input  logic              rst_req,
  input  logic [PTR_W-1:0]  sq_depth,
  input  logic [PTR_W-1:0]  cq_depth,
  input  logic [PTR_W-1:0]  sq_tail,
  input  logic [PTR_W-1:0]  cq_head,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [PTR_W-1:0]  fetch_idx,
  input  logic              done_valid,
  input  logic              done_err,
  input  logic              done_irq_req,
  output chan_state_e       state,
  output logic              evt_cpl_irq,
  output logic              evt_err
);

  localparam int CNT_W = $clog2(RESET_CYC + 1);

  chan_state_e      state_q, state_n, dec_state;
  logic [PTR_W-1:0] sq_head_q, sq_head_n, cq_tail_q, cq_tail_n;
  logic             issued_q, issued_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cq_full, has_work, accept, finish, ptr_we;

  function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cq_full     = (ring_step(cq_tail_q, cq_depth) == cq_head);
    has_work    = (sq_head_q != sq_tail);
    fetch_valid = (state_q == ST_BUSY) && !issued_q;
    fetch_idx   = sq_head_q;
    accept      = fetch_valid && fetch_ready;
    finish      = (state_q == ST_BUSY) && issued_q && done_valid;
    evt_cpl_irq = finish && !done_err && done_irq_req;
    evt_err     = finish && done_err;
    state       = state_q;
  end

  // Decision taken from an idle point (IDLE or the completion cycle)
  always_comb begin
    dec_state = ST_IDLE;
    if (enable) begin
      if (pause)         dec_state = ST_PAUSED;
      else if (has_work) dec_state = cq_full ? ST_CQFULL : ST_BUSY;
    end
  end

  always_comb begin
    state_n   = state_q;
    issued_n  = issued_q;
    cnt_n     = cnt_q;
    sq_head_n = sq_head_q;
    cq_tail_n = cq_tail_q;
    ptr_we    = 1'b0;
    if (rst_req) begin
      state_n  = ST_CLEAR;
      issued_n = 1'b0;
      cnt_n    = CNT_W'(RESET_CYC - 1);
      sq_head_n = '0;
      cq_tail_n = '0;
      ptr_we   = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: state_n = dec_state;
        ST_BUSY: begin
          if (accept) issued_n = 1'b1;
          if (finish) begin
            issued_n = 1'b0;
            if (done_err) state_n = ST_FAULT;
            else begin
              state_n   = ST_DONE;
              sq_head_n = ring_step(sq_head_q, sq_depth);
              cq_tail_n = ring_step(cq_tail_q, cq_depth);
              ptr_we    = 1'b1;
            end
          end
        end
        ST_PAUSED: if (!pause || !enable) state_n = ST_IDLE;
        ST_CQFULL: if (!cq_full || pause || !enable) state_n = ST_IDLE;
        ST_CLEAR: begin
          if (cnt_q == '0) state_n = ST_IDLE;
          else             cnt_n   = cnt_q - 1'b1;
        end
        ST_FAULT:  state_n = ST_FAULT;
        default:   state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_n;
      issued_q <= issued_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_head_q <= '0;
      cq_tail_q <= '0;
    end else if (ptr_we) begin
      sq_head_q <= sq_head_n;
      cq_tail_q <= cq_tail_n;
    end
  end

  assert_offer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !rst_req) |=> (fetch_valid && $stable(fetch_idx)));

  assert_paused_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSED) |-> !fetch_valid);

  assert_cqfull_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CQFULL) |-> !fetch_valid);

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && !rst_req) |=> (state_q == ST_FAULT && $stable(sq_head_q)));

  assert_clear_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (state_q == ST_CLEAR && sq_head_q == '0 && cq_tail_q == '0 && !fetch_valid));

  assert_cpl_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !done_err && !rst_req) |=> (state_q == ST_DONE));

endmodule

// File: rtl/qpdma_irq.sv
module qpdma_irq
  import qpdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_cpl_irq,
  input  logic              evt_err,
  input  logic              clr_we,
  input  logic [INT_W-1:0]  clr_bits,
  input  logic [INT_W-1:0]  int_mask,
  output logic [INT_W-1:0]  int_sts,
  output logic              irq
);

  logic [INT_W-1:0] set_v, sts_n;
  logic             sts_we;

  always_comb begin
    set_v              = '0;
    set_v[INT_CPL_BIT] = evt_cpl_irq;
    set_v[INT_ERR_BIT] = evt_err;
    sts_we             = clr_we || evt_cpl_irq || evt_err;
    // a new event wins over a clear in the same cycle
    sts_n              = (int_sts & ~(clr_we ? clr_bits : '0)) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      int_sts <= '0;
    else if (sts_we) int_sts <= sts_n;
  end

  always_comb irq = |(int_sts & ~int_mask);

  assert_cpl_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cpl_irq |=> int_sts[INT_CPL_BIT]);

  assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> int_sts[INT_ERR_BIT]);

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (&clr_bits) && !evt_cpl_irq && !evt_err) |=> !irq);

endmodule

// File: rtl/qpdma_chan_ctrl.sv
module qpdma_chan_ctrl
  import qpdma_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int RESET_CYC = 4,
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [PTR_W-1:0]  fetch_idx,
  input  logic              done_valid,
  input  logic              done_err,
  input  logic              done_irq_req,
  output logic              irq
);

  chan_state_e      state;
  logic [INT_W-1:0] int_sts, int_mask;
  logic [PTR_W-1:0] sq_depth, cq_depth, sq_tail, cq_head;
  logic             enable, pause, rst_req, sts_clr_we, evt_cpl_irq, evt_err;

  qpdma_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .state, .int_sts, .sq_depth, .cq_depth, .sq_tail, .cq_head,
    .enable, .pause, .rst_req, .sts_clr_we, .int_mask
  );

  qpdma_seq #(.PTR_W(PTR_W), .RESET_CYC(RESET_CYC)) u_seq (
    .clk, .rst_n, .enable, .pause, .rst_req, .sq_depth, .cq_depth,
    .sq_tail, .cq_head, .fetch_valid, .fetch_ready, .fetch_idx,
    .done_valid, .done_err, .done_irq_req, .state, .evt_cpl_irq, .evt_err
  );

  qpdma_irq u_irq (
    .clk, .rst_n, .evt_cpl_irq, .evt_err, .clr_we(sts_clr_we),
    .clr_bits(reg_wdata[INT_W-1:0]), .int_mask, .int_sts, .irq
  );

endmodule

// File: tb/test_qpdma_chan_ctrl.sv
module test_qpdma_chan_ctrl;

  localparam int DEPTH = 1024;
  localparam int RST_C = 4;
  localparam int PW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fetch_valid, fetch_ready, done_valid, done_err, done_irq_req, irq;
  logic [PW-1:0] fetch_idx;

  always #5 clk = ~clk;

  qpdma_chan_ctrl #(.DEPTH(DEPTH), .RESET_CYC(RST_C)) i_qpdma_chan_ctrl (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .fetch_valid, .fetch_ready, .fetch_idx, .done_valid, .done_err,
    .done_irq_req, .irq
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- fetch engine model ----------------
  int  acc_q[$];
  int  done_cnt = 0;
  bit  eng_block = 0, eng_flush = 0, eng_err = 0, eng_irq = 0, eng_rand_irq = 0;
  bit  irq_any = 0;
  int  eng_lat_min = 2, eng_lat_span = 3;

  initial begin
    bit busy = 0, prev_hs = 0;
    int lat = 0, prev_idx = 0;
    fetch_ready = 0; done_valid = 0; done_err = 0; done_irq_req = 0;
    forever begin
      @(negedge clk);
      done_valid = 0;
      if (!rst_n || eng_flush) begin
        fetch_ready = 0; busy = 0; prev_hs = 0;
      end else begin
        if (prev_hs) begin
          acc_q.push_back(prev_idx);
          busy = 1; prev_hs = 0; fetch_ready = 0;
          lat = eng_lat_min + int'($urandom % eng_lat_span);
        end else if (busy) begin
          if (lat == 0) begin
            done_valid = 1;
            done_err = eng_err;
            done_irq_req = eng_rand_irq ? 1'($urandom % 2) : eng_irq;
            if (done_irq_req) irq_any = 1;
            done_cnt++;
            busy = 0;
          end else lat--;
        end
        if (!busy) begin
          fetch_ready = !eng_block && ($urandom % 4 != 0);
          prev_hs = fetch_ready && fetch_valid;
          prev_idx = int'(fetch_idx);
        end
      end
    end
  end

  // ---------------- register helpers ----------------
  task automatic tick(); @(negedge clk); #2; endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(input int n);
    for (int t = 0; t < 3000 && done_cnt < n; t++) tick();
    tick(); tick();
  endtask

  task automatic wait_state(input int s);
    logic [31:0] v;
    for (int t = 0; t < 3000; t++) begin
      rd(8'h30, v);
      if (v == 32'(s)) break;
      tick();
    end
  endtask

  logic [31:0] v;
  int succ = 0;
  int base;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    report();
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1 reset values
    rd(8'h08, v); check(v == 32'd1023, "R1 sq depth reset", v, 1023);
    rd(8'h18, v); check(v == 32'd1023, "R1 cq depth reset", v, 1023);
    rd(8'h44, v); check(v == 32'h1FFF, "R1 mask reset", v, 32'h1FFF);
    rd(8'h40, v); check(v == 0, "R1 status reset", v, 0);
    rd(8'h30, v); check(v == 0, "R1 state reset", v, 0);
    check(irq == 0, "R1 irq reset", irq, 0);
    wr(8'h00, 32'h1234_5678); wr(8'h04, 32'h0000_00AB);
    wr(8'h10, 32'hCAFE_F00D); wr(8'h14, 32'h0000_0011);
    rd(8'h00, v); check(v == 32'h1234_5678, "R1 sq base lo", v, 32'h1234_5678);
    rd(8'h14, v); check(v == 32'h11, "R1 cq base hi", v, 32'h11);

    // four-entry rings, everything unmasked, enabled
    wr(8'h08, 3); wr(8'h18, 3); wr(8'h44, 0); wr(8'h20, 32'h1);
    repeat (5) tick();
    check(fetch_valid == 0, "R2 no offer when head equals tail", fetch_valid, 0);

    // R2, R6, R9: two entries with interrupt request
    eng_irq = 1;
    wr(8'h0C, 2);
    wait_done(2); succ += 2;
    wait_state(0);
    check(acc_q.size() == 2 && acc_q[0] == 0 && acc_q[1] == 1, "R2 order 0,1",
          acc_q.size() > 1 ? acc_q[1] : -1, 1);
    rd(8'h40, v); check(v[0] == 1, "R6 completion sets bit0", v, 1);
    check(irq == 1, "R9 irq on unmasked bit", irq, 1);
    wr(8'h40, 32'h1FFF);
    rd(8'h40, v); check(v == 0 && irq == 0, "R9 write ones clears", v, 0);

    // R5 full completion ring, R6 no request
    eng_irq = 0;
    wr(8'h0C, 0);
    wait_done(succ + 1); succ += 1;
    wait_state(6);
    rd(8'h30, v); check(v == 6, "R5 state WAIT", v, 6);
    repeat (6) tick();
    check(fetch_valid == 0 && acc_q.size() == 3, "R5 nothing offered while full",
          acc_q.size(), 3);
    wr(8'h1C, 3);
    wait_done(succ + 1); succ += 1;
    check(acc_q[3] == 3, "R5 released entry 3", acc_q[3], 3);
    rd(8'h40, v); check(v[0] == 0, "R6 no request leaves bit0", v, 0);

    // R3 wrap, R9 mask
    wr(8'h44, 32'h1); eng_irq = 1;
    wr(8'h0C, 1);
    wait_done(succ + 1); succ += 1;
    check(acc_q[4] == 0, "R3 head wraps to 0", acc_q[4], 0);
    rd(8'h40, v); check(v[0] == 1 && irq == 0, "R9 masked bit holds irq low", irq, 0);
    wr(8'h44, 0);
    check(irq == 1, "R9 unmask raises irq", irq, 1);
    wr(8'h40, 32'h1FFF); eng_irq = 0;

    // R4 pause with entry in flight, R10 state sequence
    wr(8'h1C, 32'(succ % 4));
    eng_lat_min = 20; eng_lat_span = 1;
    base = acc_q.size();
    wr(8'h0C, 3);
    for (int t = 0; t < 500 && acc_q.size() == base; t++) tick();
    rd(8'h30, v); check(v == 1, "R10 RUN while outstanding", v, 1);
    wr(8'h20, 32'h11);
    for (int t = 0; t < 500 && done_cnt == succ; t++) tick();
    succ += 1;
    tick(); rd(8'h30, v); check(v == 2, "R10 CPL after completion", v, 2);
    tick(); rd(8'h30, v); check(v == 3, "R4 PAUSE after in-flight entry", v, 3);
    repeat (8) tick();
    check(fetch_valid == 0 && acc_q.size() == base + 1, "R4 no offer while paused",
          acc_q.size(), base + 1);
    eng_lat_min = 2; eng_lat_span = 3;
    wr(8'h20, 32'h1);
    wait_done(succ + 1); succ += 1;
    check(acc_q[base] == 1 && acc_q[base + 1] == 2, "R4 resume at saved head",
          acc_q[base + 1], 2);

    // R11 disabled doorbell
    wr(8'h1C, 32'(succ % 4));
    wr(8'h20, 0);
    wr(8'h0C, 0);
    repeat (8) tick();
    rd(8'h30, v);
    check(fetch_valid == 0 && v == 0, "R11 disabled ignores doorbell", fetch_valid, 0);
    wr(8'h20, 1);
    wait_done(succ + 1); succ += 1;
    check(acc_q[acc_q.size() - 1] == 3, "R11 enable starts entry 3",
          acc_q[acc_q.size() - 1], 3);

    // R7 error
    wr(8'h1C, 32'(succ % 4));
    eng_err = 1;
    wr(8'h0C, 1);
    wait_done(done_cnt + 1);
    eng_err = 0;
    rd(8'h30, v); check(v == 5, "R7 ABORT after error", v, 5);
    rd(8'h40, v); check(v[1] == 1 && irq == 1, "R7 error sets bit1", v, 2);
    base = acc_q.size();
    wr(8'h0C, 2);
    repeat (10) tick();
    check(fetch_valid == 0 && acc_q.size() == base, "R7 no offer after error",
          acc_q.size(), base);
    wr(8'h40, 32'h1FFF);

    // R8 channel reset timing
    wr(8'h20, 0);
    wr(8'h24, 1);
    rd(8'h30, v); check(v == 7, "R8 BUFFCLR entered", v, 7);
    rd(8'h24, v); check(v[0] == 1, "R8 reset bit reads busy", v, 1);
    repeat (RST_C - 1) tick();
    rd(8'h30, v); check(v == 7, "R8 BUFFCLR last cycle", v, 7);
    tick();
    rd(8'h30, v); check(v == 0, "R8 IDLE after RESET_CYC", v, 0);

    // R8 reset drops a pending offer
    wr(8'h0C, 0); wr(8'h1C, 0);
    eng_block = 1;
    wr(8'h20, 1); wr(8'h0C, 1);
    repeat (4) tick();
    check(fetch_valid == 1 && fetch_idx == 0, "R8 head cleared to 0", fetch_idx, 0);
    eng_flush = 1;
    wr(8'h20, 0); wr(8'h24, 1);
    check(fetch_valid == 0, "R8 pending offer dropped", fetch_valid, 0);
    wait_state(0);
    wr(8'h0C, 0); wr(8'h1C, 0);
    eng_flush = 0; eng_block = 0;

    // randomized batches on an eight-entry ring
    begin
      int sw_tail = 0, exp_head = 0, bad = 0, n, d0;
      wr(8'h08, 7); wr(8'h18, 7); wr(8'h40, 32'h1FFF);
      wr(8'h20, 1);
      eng_rand_irq = 1;
      for (int b = 0; b < 20; b++) begin
        n = 1 + int'($urandom % 7);
        irq_any = 0;
        base = acc_q.size();
        d0 = done_cnt;
        sw_tail = (sw_tail + n) % 8;
        wr(8'h0C, 32'(sw_tail));
        wait_done(d0 + n);
        wait_state(0);
        bad = 0;
        for (int i = 0; i < n; i++)
          if (acc_q.size() <= base + i || acc_q[base + i] != (exp_head + i) % 8) bad++;
        check(bad == 0 && acc_q.size() == base + n, "R2 R3 random batch order",
              acc_q.size() - base, n);
        exp_head = (exp_head + n) % 8;
        rd(8'h40, v);
        check(v[0] == irq_any, "R6 random batch status bit0", v[0], irq_any);
        wr(8'h40, 32'h1FFF);
        wr(8'h1C, 32'(sw_tail));
      end
    end

    report();
  end

endmodule